// File: doc/BRIEF.md
# Multi-Table Page Table Walker

This block resolves translation misses from an instruction TLB and a data TLB. It keeps no translation state of its own. For each miss it reads page table entries from memory, compares them against the missing virtual address, and returns either a physical address or a fault to the TLB that asked. Up to `NUM_TBL` page tables can be set up, and each one has its own enable, base physical address and page size. Virtual addresses are 48 bits wide and physical addresses are 40 bits wide.

A walk follows one of three search policies. In sequential mode the tables are probed one at a time. In parallel mode every enabled table is read without waiting for earlier answers. In predicted mode the first probe goes to a table picked by two virtual-address bits, and a miss there falls back to the other tables.

The miss ports, the memory request port, the memory response port and the fill port all use valid/ready. An offer that is raised is held, with its payload unchanged, until ready is seen high at a clock edge. Ready on the miss ports may depend on the other port's valid, but never on its own port's valid. Memory returns responses in the order the requests were issued. The configuration inputs are plain levels and must stay stable while a walk is in progress.

Top module: `multi_table_walker`

## Requirements
- R1: After reset, `fill_valid` and `mem_req_valid` are low and both miss ports show ready.
- R2: Only one walk runs at a time, and both miss-port readies are low until its fill is taken. When both ports are valid in the same idle cycle, the first such contest goes to the data TLB. Each later contest goes to the port that lost the previous one.
- R3: The entry address for table t is `base_t + 8 * (VPN mod 2^IDX_W)`, where `VPN = VA >> s`. The shift s is 13, 16, 22 or 28 for size codes 0, 1, 2 and 3 (8 KB, 64 KB, 4 MB and 256 MB pages).
- R4: A 64-bit entry has its valid flag in bit 63, a 36-bit tag in bits 62:27 and a 27-bit physical page number in bits 26:0. It hits when the valid flag is set and the tag equals the VPN. The physical address is `{ppn, 13'b0}` with its low s bits replaced by the low s bits of the VA.
- R5: Mode 0 (and mode 3) probes the enabled tables in ascending order. Each probe waits for the previous response, and the walk stops at the first hit.
- R6: Mode 1 issues a read to every enabled table in ascending order without waiting for responses. The lowest-numbered table that hits supplies the translation.
- R7: Mode 2 probes table `VA[PRED_LSB+1:PRED_LSB]` first if that table is enabled. It then probes the remaining enabled tables in ascending order, one at a time, and stops at the first hit.
- R8: A walk in which no probed table hits returns `fill_fault=1` with `fill_pa=0`. A disabled table is never read, so with no table enabled the walk faults without any memory request.
- R9: `mem_req_addr` and every fill output hold steady while their valid is high and ready is low. `fill_to_dtlb` is 1 for a data-TLB miss and 0 for an instruction-TLB miss.
- R10: In modes 0, 2 and 3 at most one memory read is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| itlb_miss_valid | input | 1 | Instruction-TLB miss offered |
| itlb_miss_ready | output | 1 | Instruction-TLB miss accepted |
| itlb_miss_va | input | 48 | Missing virtual address, instruction side |
| dtlb_miss_valid | input | 1 | Data-TLB miss offered |
| dtlb_miss_ready | output | 1 | Data-TLB miss accepted |
| dtlb_miss_va | input | 48 | Missing virtual address, data side |
| cfg_tbl_en | input | NUM_TBL | Per-table enable |
| cfg_tbl_base | input | NUM_TBL*40 | Per-table base physical address (8-byte aligned), table t at bits 40t+39:40t |
| cfg_tbl_size | input | NUM_TBL*2 | Per-table page-size code, table t at bits 2t+1:2t |
| cfg_mode | input | 2 | Search policy: 0 sequential, 1 parallel, 2 predicted, 3 sequential |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 40 | Physical address of the entry |
| mem_rsp_valid | input | 1 | Entry data returned |
| mem_rsp_ready | output | 1 | Walker accepts the returned entry |
| mem_rsp_data | input | 64 | Returned page table entry |
| fill_valid | output | 1 | Walk result valid |
| fill_ready | input | 1 | Requesting TLB takes the result |
| fill_to_dtlb | output | 1 | 1 when the result is for the data TLB |
| fill_fault | output | 1 | No table held a matching entry |
| fill_pa | output | 40 | Translated physical address |
| fill_size | output | 2 | Page-size code of the matching table |

## Verification
The bench runs the same few addresses through all three policies and several enable masks. Each run checks the translation, the number of reads issued and the first address read. The read count separates sequential probing (which stops early) from parallel probing (which reads every enabled table). The first address shows whether prediction redirected the walk. One address is stored in two tables of different page size, which exposes whether the lowest table wins in parallel mode. A second address shares an entry slot with a stored one but not its tag, and an empty enable mask and a disabled predicted table cover the fault and fallback paths. Simultaneous misses on both ports, a stalled fill and a stalled memory port cover arbitration and back-pressure.

// File: rtl/mtw_pkg.sv
`timescale 1ns/1ps
package mtw_pkg;
  localparam int VA_W      = 48;
  localparam int PA_W      = 40;
  localparam int ENTRY_W   = 64;
  localparam int SZ_W      = 2;
  localparam int MIN_SHIFT = 13;
  localparam int PPN_W     = PA_W - MIN_SHIFT;
  localparam int TAG_W     = ENTRY_W - 1 - PPN_W;

  typedef enum logic [1:0] {
    MODE_SEQ     = 2'd0,
    MODE_PAR     = 2'd1,
    MODE_PRED    = 2'd2,
    MODE_SEQ_ALT = 2'd3
  } walk_mode_e;

  function automatic logic [4:0] size_shift(input logic [SZ_W-1:0] code);
    case (code)
      2'd0:    return 5'd13;
      2'd1:    return 5'd16;
      2'd2:    return 5'd22;
      default: return 5'd28;
    endcase
  endfunction
endpackage

// File: rtl/mtw_tbl_addr.sv
`timescale 1ns/1ps
module mtw_tbl_addr import mtw_pkg::*; #(
  parameter int IDX_W = 10
) (
  input  logic [VA_W-1:0] va,
  input  logic [PA_W-1:0] base,
  input  logic [SZ_W-1:0] size_code,
  output logic [PA_W-1:0] entry_addr
);
  logic [IDX_W-1:0] idx;

  always_comb begin
    idx        = IDX_W'(va >> size_shift(size_code));
    entry_addr = base + (PA_W'(idx) << 3);
  end
endmodule

// File: rtl/mtw_entry_check.sv
`timescale 1ns/1ps
module mtw_entry_check import mtw_pkg::*; (
  input  logic [VA_W-1:0]    va,
  input  logic [SZ_W-1:0]    size_code,
  input  logic [ENTRY_W-1:0] entry,
  output logic               hit,
  output logic [PA_W-1:0]    pa
);
  logic [TAG_W-1:0] vpn;
  logic [PA_W-1:0]  off_mask;

  always_comb begin
    vpn      = TAG_W'(va >> size_shift(size_code));
    off_mask = (PA_W'(1) << size_shift(size_code)) - PA_W'(1);
    hit      = entry[ENTRY_W-1] && (entry[ENTRY_W-2 -: TAG_W] == vpn);
    pa       = ({entry[PPN_W-1:0], {MIN_SHIFT{1'b0}}} & ~off_mask) |
               (va[PA_W-1:0] & off_mask);
  end
endmodule

// File: rtl/mtw_miss_arb.sv
`timescale 1ns/1ps
module mtw_miss_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic idle,
  input  logic i_valid,
  input  logic d_valid,
  output logic i_ready,
  output logic d_ready,
  output logic start,
  output logic take_d
);
  logic prio_d;
  logic i_go, d_go;

  assign i_ready = idle && !(d_valid && prio_d);
  assign d_ready = idle && !(i_valid && !prio_d);
  assign i_go    = i_valid && i_ready;
  assign d_go    = d_valid && d_ready;
  assign start   = i_go || d_go;
  assign take_d  = d_go;

  always_ff @(posedge clk) begin
    if (!rst_n)                           prio_d <= 1'b1;
    else if (i_valid && d_valid && start) prio_d <= !d_go;
  end

  // R2
  single_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({i_go, d_go}));
endmodule

// File: rtl/multi_table_walker.sv
`timescale 1ns/1ps
module multi_table_walker import mtw_pkg::*; #(
  parameter int NUM_TBL  = 4,
  parameter int IDX_W    = 10,
  parameter int PRED_LSB = 22
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    itlb_miss_valid,
  output logic                    itlb_miss_ready,
  input  logic [VA_W-1:0]         itlb_miss_va,
  input  logic                    dtlb_miss_valid,
  output logic                    dtlb_miss_ready,
  input  logic [VA_W-1:0]         dtlb_miss_va,
  input  logic [NUM_TBL-1:0]      cfg_tbl_en,
  input  logic [NUM_TBL*PA_W-1:0] cfg_tbl_base,
  input  logic [NUM_TBL*SZ_W-1:0] cfg_tbl_size,
  input  logic [1:0]              cfg_mode,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [PA_W-1:0]         mem_req_addr,
  input  logic                    mem_rsp_valid,
  output logic                    mem_rsp_ready,
  input  logic [ENTRY_W-1:0]      mem_rsp_data,
  output logic                    fill_valid,
  input  logic                    fill_ready,
  output logic                    fill_to_dtlb,
  output logic                    fill_fault,
  output logic [PA_W-1:0]         fill_pa,
  output logic [SZ_W-1:0]         fill_size
);
  localparam int TID_W = (NUM_TBL > 1) ? $clog2(NUM_TBL) : 1;

  typedef enum logic [1:0] {ST_IDLE, ST_WALK, ST_FILL} state_e;

  state_e             state;
  walk_mode_e         mode_q;
  logic [VA_W-1:0]    va_q, start_va;
  logic               to_d_q, start, take_d;
  logic [NUM_TBL-1:0] pending, inflight, pend_nx, infl_nx;
  logic               pred_first, first_nx, hit_q, hit_nx;
  logic [PA_W-1:0]    pa_q, pa_nx, rsp_pa;
  logic [SZ_W-1:0]    size_q, size_nx, rsp_size;
  logic [TID_W-1:0]   next_tid, rsp_tid, start_pred;
  logic               req_fire, rsp_fire, rsp_hit, walk_done;
  logic [PA_W-1:0]    tbl_addr [NUM_TBL];

  function automatic logic [TID_W-1:0] lowest_set(input logic [NUM_TBL-1:0] m);
    logic [TID_W-1:0] r;
    r = '0;
    for (int i = NUM_TBL - 1; i >= 0; i--) if (m[i]) r = TID_W'(i);
    return r;
  endfunction

  mtw_miss_arb u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .idle    (state == ST_IDLE),
    .i_valid (itlb_miss_valid),
    .d_valid (dtlb_miss_valid),
    .i_ready (itlb_miss_ready),
    .d_ready (dtlb_miss_ready),
    .start   (start),
    .take_d  (take_d)
  );

  assign start_va   = take_d ? dtlb_miss_va : itlb_miss_va;
  assign start_pred = start_va[PRED_LSB +: TID_W];

  for (genvar t = 0; t < NUM_TBL; t++) begin : g_tbl
    mtw_tbl_addr #(.IDX_W(IDX_W)) u_addr (
      .va         (va_q),
      .base       (cfg_tbl_base[t*PA_W +: PA_W]),
      .size_code  (cfg_tbl_size[t*SZ_W +: SZ_W]),
      .entry_addr (tbl_addr[t])
    );
  end

  assign next_tid      = pred_first ? va_q[PRED_LSB +: TID_W] : lowest_set(pending);
  assign rsp_tid       = lowest_set(inflight);
  assign rsp_size      = cfg_tbl_size[rsp_tid*SZ_W +: SZ_W];
  assign mem_req_valid = (state == ST_WALK) && (pending != '0) &&
                         (mode_q == MODE_PAR || inflight == '0);
  assign mem_req_addr  = tbl_addr[next_tid];
  assign mem_rsp_ready = (state == ST_WALK) && (inflight != '0);
  assign req_fire      = mem_req_valid && mem_req_ready;
  assign rsp_fire      = mem_rsp_valid && mem_rsp_ready;
  assign walk_done     = (pending == '0) && (inflight == '0);

  mtw_entry_check u_check (
    .va        (va_q),
    .size_code (rsp_size),
    .entry     (mem_rsp_data),
    .hit       (rsp_hit),
    .pa        (rsp_pa)
  );

  always_comb begin
    pend_nx  = pending;
    infl_nx  = inflight;
    first_nx = pred_first;
    hit_nx   = hit_q;
    pa_nx    = pa_q;
    size_nx  = size_q;
    if (req_fire) begin
      pend_nx[next_tid] = 1'b0;
      infl_nx[next_tid] = 1'b1;
      first_nx          = 1'b0;
    end
    if (rsp_fire) begin
      infl_nx[rsp_tid] = 1'b0;
      if (rsp_hit && !hit_q) begin
        hit_nx  = 1'b1;
        pa_nx   = rsp_pa;
        size_nx = rsp_size;
        if (mode_q != MODE_PAR) pend_nx = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      mode_q     <= MODE_SEQ;
      va_q       <= '0;
      to_d_q     <= 1'b0;
      pending    <= '0;
      inflight   <= '0;
      pred_first <= 1'b0;
      hit_q      <= 1'b0;
      pa_q       <= '0;
      size_q     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          state      <= ST_WALK;
          mode_q     <= walk_mode_e'(cfg_mode);
          va_q       <= start_va;
          to_d_q     <= take_d;
          pending    <= cfg_tbl_en;
          inflight   <= '0;
          pred_first <= (cfg_mode == MODE_PRED) && cfg_tbl_en[start_pred];
          hit_q      <= 1'b0;
          pa_q       <= '0;
          size_q     <= '0;
        end
        ST_WALK: begin
          pending    <= pend_nx;
          inflight   <= infl_nx;
          pred_first <= first_nx;
          hit_q      <= hit_nx;
          pa_q       <= pa_nx;
          size_q     <= size_nx;
          if (walk_done) state <= ST_FILL;
        end
        ST_FILL: if (fill_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign fill_valid   = (state == ST_FILL);
  assign fill_to_dtlb = to_d_q;
  assign fill_fault   = !hit_q;
  assign fill_pa      = pa_q;
  assign fill_size    = size_q;

  // R9
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R9
  fill_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !fill_ready) |=>
      (fill_valid && $stable(fill_pa) && $stable(fill_fault) && $stable(fill_to_dtlb)));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WALK && mode_q != MODE_PAR) |-> ($countones(inflight) <= 1));

  // R8
  enabled_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> cfg_tbl_en[next_tid]);

  // R2
  no_accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |-> (!itlb_miss_ready && !dtlb_miss_ready));
endmodule

// File: tb/multi_table_walker_bench.sv
`timescale 1ns/1ps
module multi_table_walker_bench;
  import mtw_pkg::*;

  localparam int NT = 4;
  localparam logic [47:0] VA1 = 48'h0000_1234_5678;
  localparam logic [47:0] VA2 = 48'h0000_0AC0_1000;
  localparam logic [47:0] VA3 = 48'h0000_7777_0000;
  localparam logic [47:0] VA4 = 48'h0001_1234_5678;
  localparam logic [47:0] VA5 = 48'h0000_0A80_1000;

  typedef struct packed {
    logic [1:0]  mode;
    logic [3:0]  en;
    logic [47:0] va;
    logic        to_d;
    logic        hit;
    logic [1:0]  tbl;
    logic [2:0]  nreq;
    logic [1:0]  first;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'hF, VA2, 1'b1, 1'b1, 2'd1, 3'd2, 2'd0},
    '{2'd1, 4'hF, VA2, 1'b0, 1'b1, 2'd1, 3'd4, 2'd0},
    '{2'd2, 4'hF, VA2, 1'b1, 1'b1, 2'd3, 3'd1, 2'd3},
    '{2'd0, 4'hF, VA1, 1'b0, 1'b1, 2'd2, 3'd3, 2'd0},
    '{2'd2, 4'hF, VA1, 1'b1, 1'b1, 2'd2, 3'd3, 2'd0},
    '{2'd1, 4'hF, VA1, 1'b0, 1'b1, 2'd2, 3'd4, 2'd0},
    '{2'd0, 4'hF, VA3, 1'b1, 1'b0, 2'd0, 3'd4, 2'd0},
    '{2'd2, 4'hF, VA4, 1'b0, 1'b0, 2'd0, 3'd4, 2'd0},
    '{2'd0, 4'hD, VA2, 1'b1, 1'b1, 2'd3, 3'd3, 2'd0},
    '{2'd2, 4'h7, VA2, 1'b0, 1'b1, 2'd1, 3'd2, 2'd0},
    '{2'd1, 4'h5, VA2, 1'b1, 1'b0, 2'd0, 3'd2, 2'd0},
    '{2'd3, 4'hF, VA2, 1'b0, 1'b1, 2'd1, 3'd2, 2'd0},
    '{2'd0, 4'h0, VA2, 1'b1, 1'b0, 2'd0, 3'd0, 2'd0},
    '{2'd1, 4'hC, VA2, 1'b0, 1'b1, 2'd3, 3'd2, 2'd2},
    '{2'd2, 4'hF, VA5, 1'b1, 1'b1, 2'd1, 3'd3, 2'd2},
    '{2'd0, 4'hF, VA5, 1'b0, 1'b1, 2'd1, 3'd2, 2'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic iv = 1'b0, dv = 1'b0, i_rdy, d_rdy;
  logic [47:0] iva = '0, dva = '0;
  logic [NT-1:0] cfg_en = '0;
  logic [NT*40-1:0] cfg_base;
  logic [NT*2-1:0] cfg_size;
  logic [1:0] cfg_mode = 2'd0;
  logic mreq_v, mreq_r = 1'b1, mrsp_v = 1'b0, mrsp_r;
  logic [39:0] mreq_a;
  logic [63:0] mrsp_d = '0;
  logic fv, fr = 1'b1, f_d, f_fault;
  logic [39:0] f_pa;
  logic [1:0] f_size;

  int total = 0, fails = 0, cyc = 0, nreq = 0;
  logic [39:0] first_addr = '0;
  logic mem_stall = 1'b0, rsp_go = 1'b0;
  logic [39:0] q[$];

  always #10 clk = !clk;

  multi_table_walker u_multi_table_walker (
    .clk(clk), .rst_n(rst_n),
    .itlb_miss_valid(iv), .itlb_miss_ready(i_rdy), .itlb_miss_va(iva),
    .dtlb_miss_valid(dv), .dtlb_miss_ready(d_rdy), .dtlb_miss_va(dva),
    .cfg_tbl_en(cfg_en), .cfg_tbl_base(cfg_base), .cfg_tbl_size(cfg_size),
    .cfg_mode(cfg_mode),
    .mem_req_valid(mreq_v), .mem_req_ready(mreq_r), .mem_req_addr(mreq_a),
    .mem_rsp_valid(mrsp_v), .mem_rsp_ready(mrsp_r), .mem_rsp_data(mrsp_d),
    .fill_valid(fv), .fill_ready(fr), .fill_to_dtlb(f_d), .fill_fault(f_fault),
    .fill_pa(f_pa), .fill_size(f_size)
  );

  // Table t has size code t: 8 KB, 64 KB, 4 MB, 256 MB pages
  function automatic int shift_of(input int t);
    int s [4] = '{13, 16, 22, 28};
    return s[t];
  endfunction
  function automatic logic [39:0] base_of(input int t);
    return 40'h10_0000 * 40'(t + 1);
  endfunction
  function automatic logic [39:0] slot_addr(input logic [47:0] va, input int t);
    logic [47:0] v = va >> shift_of(t);
    return base_of(t) + 40'(v % 48'd1024) * 40'd8;
  endfunction
  function automatic logic [26:0] ppn_of(input logic [47:0] va, input int t);
    return 27'(va >> 9) ^ 27'(32'h0135_79B * (t + 3));
  endfunction
  function automatic logic [63:0] entry_of(input logic [47:0] va, input int t);
    return {1'b1, 36'(va >> shift_of(t)), ppn_of(va, t)};
  endfunction
  function automatic logic [39:0] pa_of(input logic [47:0] va, input int t);
    logic [39:0] lowmask = (40'd1 << shift_of(t)) - 40'd1;
    return ({ppn_of(va, t), 13'd0} & ~lowmask) | (va[39:0] & lowmask);
  endfunction

  logic [47:0] e_va [4] = '{VA1, VA2, VA2, VA5};
  int          e_tb [4] = '{2, 1, 3, 1};

  function automatic logic [63:0] mem_read(input logic [39:0] a);
    for (int k = 0; k < 4; k++)
      if (slot_addr(e_va[k], e_tb[k]) == a) return entry_of(e_va[k], e_tb[k]);
    return 64'd0;
  endfunction

  initial begin
    for (int t = 0; t < NT; t++) begin
      cfg_base[t*40 +: 40] = base_of(t);
      cfg_size[t*2 +: 2]   = 2'(t);
    end
  end

  // Memory model: in-order, one response per cycle, periodic request stalls
  always @(negedge clk) begin
    if (rsp_go) begin
      void'(q.pop_front());
      mrsp_v = 1'b0;
    end
    if (!mrsp_v && q.size() > 0) begin
      mrsp_v = 1'b1;
      mrsp_d = mem_read(q[0]);
    end
    rsp_go = mrsp_v && mrsp_r;
    mreq_r = !mem_stall && (cyc % 3 != 0);
    if (mreq_v && mreq_r) begin
      if (nreq == 0) first_addr = mreq_a;
      nreq++;
      q.push_back(mreq_a);
    end
  end

  task automatic check(input bit ok, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      total++;
      fails++;
      $display("FAIL R5 watchdog: actual=%0d expected<%0d", cyc, 50000);
      summary();
    end
  end

  task automatic issue(input logic [47:0] va, input logic to_d);
    @(negedge clk);
    nreq = 0;
    if (to_d) begin dv = 1'b1; dva = va; end
    else begin iv = 1'b1; iva = va; end
    #1;
    while (!(to_d ? d_rdy : i_rdy)) begin @(negedge clk); #1; end
    @(negedge clk);
    iv = 1'b0;
    dv = 1'b0;
  endtask

  task automatic wait_fill();
    while (!fv) @(negedge clk);
  endtask

  logic got [4];
  int n;
  logic i_go, d_go;
  logic [39:0] held;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(fv == 1'b0, "R1 fill_valid after reset", 64'(fv), 64'd0);
    check(mreq_v == 1'b0, "R1 mem_req_valid after reset", 64'(mreq_v), 64'd0);
    check(i_rdy == 1'b1, "R1 itlb ready after reset", 64'(i_rdy), 64'd1);
    check(d_rdy == 1'b1, "R1 dtlb ready after reset", 64'(d_rdy), 64'd1);
    rst_n = 1'b1;

    // R3 R4 R5 R6 R7 R8 R9: vector table
    for (int v = 0; v < NV; v++) begin
      cfg_mode = VECS[v].mode;
      cfg_en   = VECS[v].en;
      issue(VECS[v].va, VECS[v].to_d);
      wait_fill();
      check(f_fault == !VECS[v].hit, $sformatf("R8 vec%0d fault", v),
            64'(f_fault), 64'(!VECS[v].hit));
      check(f_pa == (VECS[v].hit ? pa_of(VECS[v].va, VECS[v].tbl) : 40'd0),
            $sformatf("R4 vec%0d pa", v), 64'(f_pa),
            64'(VECS[v].hit ? pa_of(VECS[v].va, VECS[v].tbl) : 40'd0));
      check(f_d == VECS[v].to_d, $sformatf("R9 vec%0d dest", v),
            64'(f_d), 64'(VECS[v].to_d));
      check(nreq == int'(VECS[v].nreq), $sformatf("R6 R5 R7 vec%0d read count", v),
            64'(nreq), 64'(VECS[v].nreq));
      if (VECS[v].nreq != 0)
        check(first_addr == slot_addr(VECS[v].va, VECS[v].first),
              $sformatf("R3 R7 vec%0d first read", v), 64'(first_addr),
              64'(slot_addr(VECS[v].va, VECS[v].first)));
      @(negedge clk);
    end

    // R2 arbitration: two contests, expected winners D then I
    cfg_mode = 2'd0;
    cfg_en   = 4'hF;
    for (int p = 0; p < 2; p++) begin
      @(negedge clk);
      iv = 1'b1; dv = 1'b1; iva = VA2; dva = VA1;
      #1;
      n = 0;
      while (n < 2) begin
        i_go = iv && i_rdy;
        d_go = dv && d_rdy;
        @(negedge clk);
        if (i_go) iv = 1'b0;
        if (d_go) dv = 1'b0;
        #1;
        if (fv) begin got[p*2+n] = f_d; n++; end
      end
    end
    check(got[0] == 1'b1, "R2 first contest winner", 64'(got[0]), 64'd1);
    check(got[1] == 1'b0, "R2 first contest loser", 64'(got[1]), 64'd0);
    check(got[2] == 1'b0, "R2 second contest winner", 64'(got[2]), 64'd0);
    check(got[3] == 1'b1, "R2 second contest loser", 64'(got[3]), 64'd1);

    // R9 fill back-pressure
    @(negedge clk);
    fr = 1'b0;
    issue(VA1, 1'b0);
    wait_fill();
    held = f_pa;
    repeat (3) @(negedge clk);
    check(fv == 1'b1, "R9 fill held valid", 64'(fv), 64'd1);
    check(f_pa == held && held == pa_of(VA1, 2), "R9 fill pa held", 64'(f_pa), 64'(pa_of(VA1, 2)));
    fr = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(fv == 1'b0, "R9 fill dropped after take", 64'(fv), 64'd0);

    // R9 R2 memory request back-pressure, busy walker refuses misses
    mem_stall = 1'b1;
    issue(VA2, 1'b1);
    while (!mreq_v) @(negedge clk);
    held = mreq_a;
    repeat (3) @(negedge clk);
    check(mreq_v == 1'b1 && mreq_a == held, "R9 mem request held",
          64'(mreq_a), 64'(held));
    check(held == slot_addr(VA2, 0), "R3 stalled address", 64'(held), 64'(slot_addr(VA2, 0)));
    check(i_rdy == 1'b0 && d_rdy == 1'b0, "R2 ready low during walk",
          64'({i_rdy, d_rdy}), 64'd0);
    mem_stall = 1'b0;
    wait_fill();
    check(f_pa == pa_of(VA2, 1) && !f_fault, "R5 walk after stall", 64'(f_pa), 64'(pa_of(VA2, 1)));
    @(negedge clk);

    summary();
  end
endmodule